// File: doc/BRIEF.md
# Shared-Engine Multi-Channel Serial Receiver

This block receives 8-bit asynchronous characters on sixteen serial channels and uses a single state-transition engine for all of them. An external scanner visits one channel per clock. On each visit it presents the channel index, the filtered line level of that channel, and a tick. The tick pulses once per oversample period of that channel, and a bit lasts `OVS` ticks. The block keeps every channel's context in small memories that the channel index addresses. That context is the receive state, a tick countdown, the bit index, the shift register and the two error flags. On each clock the engine reads the context of the visited channel, computes the next context and writes it back.

Whenever a channel finishes a character, the engine forms a completion word in the same cycle. The word carries the channel number, a break flag, a framing flag and the received byte, and it is pushed into an output FIFO that accepts one word on every clock. The FIFO drains through a valid/ready stream. The word at the head stays on `out_data` while `out_valid` is high and `out_ready` is low. A word is popped on each clock edge where both are high. A configuration pin chooses one or two stop bits for all channels.

Top module: `mcrx_engine`

## Requirements
- R1: On any visit to a hunting channel, a low `rx_level` starts a start-bit check, whether `rx_tick` is high or not. A high level keeps the channel hunting.
- R2: The line is sampled again OVS/2 ticks after the falling edge is found. If the line is high at that point, the edge counts as noise: no word is produced and the channel returns to hunting.
- R3: After a confirmed start bit, eight data bits are sampled at intervals of OVS ticks and assembled least significant bit first.
- R4: With `two_stop`=0 a character completes at the middle of the first stop bit. With `two_stop`=1 it completes one bit later, at the middle of the second stop bit, and the level of the second stop bit has no effect on the word.
- R5: Bit 8 of the word (framing) is 1 exactly when the first stop bit is sampled low.
- R6: Bit 9 of the word (break) is 1 exactly when the first stop bit and all eight data bits are sampled low.
- R7: The word layout is channel in bits 15:12, zeros in bits 11:10, break in bit 9, framing in bit 8 and data in bits 7:0.
- R8: Each channel keeps its own context. Channels whose ticks run at different rates and whose characters overlap in time each produce their own correct words.
- R9: `out_valid` is high while the FIFO holds a word. While `out_ready` is low, the head word stays unchanged. Words leave in the order in which they were written.
- R10: A completion that arrives while the FIFO holds DEPTH words is dropped, even if a pop happens in the same cycle. It sets `overflow`, which then stays high until reset.
- R11: After reset, `out_valid` and `overflow` are 0 and every channel is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_ch | input | 4 | Index of the channel visited this cycle |
| rx_level | input | 1 | Filtered line level of the visited channel |
| rx_tick | input | 1 | Oversample tick of the visited channel |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | 16 | Head word {channel, 2'b00, break, framing, data} |
| overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
The bench builds the block with OVS=8 and a four-entry FIFO (FIFO_AW=2). At that size a character takes about 1,300 clocks on a fast channel, so twenty overlapping characters per channel fit in the run. Eight channels that finish while `out_ready` is held low overrun the FIFO, which exercises the drop rule and the sticky flag. Odd channels tick on every second visit and even channels on every visit, so contexts at two different rates interleave in the shared engine. Measuring the time from the start edge to the word separates completion at the first stop bit from completion at the second.

// File: rtl/mcrx_pkg.sv
package mcrx_pkg;

  typedef enum logic [2:0] {
    RX_HUNT  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP1 = 3'd3,
    RX_STOP2 = 3'd4
  } rx_state_e;

  localparam int STATE_W = 3;

endpackage

// File: rtl/mcrx_chan_mem.sv
module mcrx_chan_mem #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int NENT = 1 << AW;

  logic [W-1:0] slot [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (addr == AW'(i))
        slot[i] <= wdata;
    end
  end

  assign rdata = slot[addr];

endmodule

// File: rtl/mcrx_step.sv
module mcrx_step
  import mcrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CNT_W  = 4,
  parameter int BIT_W  = 3
) (
  input  rx_state_e          cur_state,
  input  logic [CNT_W-1:0]   cur_cnt,
  input  logic [BIT_W-1:0]   cur_bit,
  input  logic               cur_fe,
  input  logic               cur_brk,
  input  logic [DATA_W-1:0]  cur_sh,
  input  logic               level,
  input  logic               tick,
  input  logic               two_stop,
  output rx_state_e          nxt_state,
  output logic [CNT_W-1:0]   nxt_cnt,
  output logic [BIT_W-1:0]   nxt_bit,
  output logic               nxt_fe,
  output logic               nxt_brk,
  output logic [DATA_W-1:0]  nxt_sh,
  output logic               done
);
  localparam logic [CNT_W-1:0] HALF_RELOAD = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_RELOAD = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT    = BIT_W'(DATA_W - 1);

  logic sample_now;
  assign sample_now = tick && (cur_cnt == '0);

  always_comb begin
    nxt_state = cur_state;
    nxt_cnt   = cur_cnt;
    nxt_bit   = cur_bit;
    nxt_fe    = cur_fe;
    nxt_brk   = cur_brk;
    nxt_sh    = cur_sh;
    done      = 1'b0;
    if (tick && cur_cnt != '0)
      nxt_cnt = cur_cnt - 1'b1;
    case (cur_state)
      RX_HUNT: begin
        if (!level) begin
          nxt_state = RX_START;
          nxt_cnt   = HALF_RELOAD;
          nxt_fe    = 1'b0;
          nxt_brk   = 1'b0;
        end
      end
      RX_START: begin
        if (sample_now) begin
          if (!level) begin
            nxt_state = RX_DATA;
            nxt_cnt   = FULL_RELOAD;
            nxt_bit   = '0;
          end else begin
            nxt_state = RX_HUNT;
          end
        end
      end
      RX_DATA: begin
        if (sample_now) begin
          nxt_sh  = {level, cur_sh[DATA_W-1:1]};
          nxt_cnt = FULL_RELOAD;
          if (cur_bit == LAST_BIT)
            nxt_state = RX_STOP1;
          else
            nxt_bit = cur_bit + 1'b1;
        end
      end
      RX_STOP1: begin
        if (sample_now) begin
          nxt_fe  = !level;
          nxt_brk = !level && (cur_sh == '0);
          if (two_stop) begin
            nxt_state = RX_STOP2;
            nxt_cnt   = FULL_RELOAD;
          end else begin
            nxt_state = RX_HUNT;
            done      = 1'b1;
          end
        end
      end
      RX_STOP2: begin
        if (sample_now) begin
          nxt_state = RX_HUNT;
          done      = 1'b1;
        end
      end
      default: nxt_state = RX_HUNT;
    endcase
  end

endmodule

// File: rtl/mcrx_fifo.sv
module mcrx_fifo #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_ready,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  output logic         dropped
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;
  logic          full, do_push, do_pop;

  assign full       = (fill == (AW+1)'(DEPTH));
  assign head_valid = (fill != '0);
  assign do_push    = push && !full;
  assign do_pop     = pop_ready && head_valid;
  assign head_data  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push)
      store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      dropped <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (push && full)
        dropped <= 1'b1;
    end
  end

endmodule

// File: rtl/mcrx_engine.sv
module mcrx_engine
  import mcrx_pkg::*;
#(
  parameter int CH_W    = 4,
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int FIFO_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CH_W-1:0]            rx_ch,
  input  logic                       rx_level,
  input  logic                       rx_tick,
  input  logic                       two_stop,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [CH_W+DATA_W+3:0]     out_data,
  output logic                       overflow
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int CTL_W  = STATE_W + CNT_W + BIT_W;
  localparam int WORD_W = CH_W + DATA_W + 4;

  logic [CTL_W-1:0]  ctl_rd, ctl_wr;
  logic [1:0]        flg_rd, flg_wr;
  logic [DATA_W-1:0] sh_rd, sh_wr;

  rx_state_e         cur_state, nxt_state;
  logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
  logic [BIT_W-1:0]  cur_bit, nxt_bit;
  logic              nxt_fe, nxt_brk, done;
  logic [WORD_W-1:0] word;

  mcrx_chan_mem #(.W(CTL_W), .AW(CH_W)) u_ctl_mem (
    .clk(clk), .rst_n(rst_n), .addr(rx_ch), .wdata(ctl_wr), .rdata(ctl_rd)
  );
  mcrx_chan_mem #(.W(2), .AW(CH_W)) u_flag_mem (
    .clk(clk), .rst_n(rst_n), .addr(rx_ch), .wdata(flg_wr), .rdata(flg_rd)
  );
  mcrx_chan_mem #(.W(DATA_W), .AW(CH_W)) u_shift_mem (
    .clk(clk), .rst_n(rst_n), .addr(rx_ch), .wdata(sh_wr), .rdata(sh_rd)
  );

  assign cur_state = rx_state_e'(ctl_rd[CTL_W-1 -: STATE_W]);
  assign cur_cnt   = ctl_rd[BIT_W +: CNT_W];
  assign cur_bit   = ctl_rd[BIT_W-1:0];

  mcrx_step #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_step (
    .cur_state(cur_state), .cur_cnt(cur_cnt), .cur_bit(cur_bit),
    .cur_fe(flg_rd[0]), .cur_brk(flg_rd[1]), .cur_sh(sh_rd),
    .level(rx_level), .tick(rx_tick), .two_stop(two_stop),
    .nxt_state(nxt_state), .nxt_cnt(nxt_cnt), .nxt_bit(nxt_bit),
    .nxt_fe(nxt_fe), .nxt_brk(nxt_brk), .nxt_sh(sh_wr), .done(done)
  );

  assign ctl_wr = {nxt_state, nxt_cnt, nxt_bit};
  assign flg_wr = {nxt_brk, nxt_fe};
  assign word   = {rx_ch, 2'b00, nxt_brk, nxt_fe, sh_rd};

  mcrx_fifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(done), .push_data(word),
    .pop_ready(out_ready), .head_valid(out_valid), .head_data(out_data),
    .dropped(overflow)
  );

endmodule

// File: rtl/mcrx_engine_chk.sv
module mcrx_engine_chk #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              overflow,
  input logic              done,
  input logic [2:0]        cur_state,
  input logic [2:0]        nxt_state,
  input logic              rx_level
);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[DATA_W+3:DATA_W+2] == 2'b00));

  // R6
  brk_implies_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[DATA_W+1]) |-> (out_data[DATA_W] && out_data[DATA_W-1:0] == '0));

  // R1
  hunt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd0 && rx_level) |-> (nxt_state == 3'd0));

  // R4
  done_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_state == 3'd3 || cur_state == 3'd4));

endmodule

bind mcrx_engine mcrx_engine_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .overflow(overflow), .done(done),
  .cur_state(cur_state), .nxt_state(nxt_state), .rx_level(rx_level)
);

// File: tb/mcrx_engine_test.sv
module mcrx_engine_test;
  localparam int OVS   = 8;
  localparam int FAW   = 2;
  localparam int DEPTH = 1 << FAW;
  localparam int NCH   = 16;
  localparam int BITCLK = OVS * 16;

  logic clk = 0, rst_n = 0;
  logic [3:0] rx_ch = 0;
  logic rx_level = 1, rx_tick = 0, two_stop = 0, out_ready = 0;
  logic out_valid, overflow;
  logic [15:0] out_data;

  always #10 clk = ~clk;

  mcrx_engine #(.CH_W(4), .DATA_W(8), .OVS(OVS), .FIFO_AW(FAW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_ch(rx_ch), .rx_level(rx_level), .rx_tick(rx_tick),
    .two_stop(two_stop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .overflow(overflow)
  );

  int nchecks = 0, nerrs = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // line driver state
  logic [15:0] req_frame [NCH];
  int req_nb [NCH], req_tpb [NCH], req_wr [NCH], req_rd [NCH];
  logic [15:0] frame [NCH];
  int nb [NCH], tpb [NCH], bitpos [NCH], tkc [NCH], vcnt [NCH];
  bit busy [NCH];
  int tx_start [NCH], last_pop [NCH];
  int cyc = 0, pop_total = 0;

  // expected words
  logic [15:0] exp_mem [NCH][32];
  int exp_wr [NCH], exp_rd [NCH];
  int flush_req = 0, flush_seen = 0;

  initial for (int c = 0; c < NCH; c++) begin
    req_wr[c] = 0; req_rd[c] = 0; busy[c] = 0; vcnt[c] = 0;
    exp_wr[c] = 0; exp_rd[c] = 0; last_pop[c] = 0; tx_start[c] = 0;
  end

  function automatic logic [15:0] exp_word(int c, logic [7:0] d, bit s1);
    bit fe = !s1;
    bit brk = !s1 && (d == 8'h00);
    return {4'(c), 2'b00, brk, fe, d};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (flush_req != flush_seen) begin
      flush_seen = flush_req;
      for (int c = 0; c < NCH; c++) exp_rd[c] = exp_wr[c];
    end
    if (rst_n && out_valid && out_ready) begin
      int ch;
      ch = int'(out_data[15:12]);
      pop_total++;
      last_pop[ch] = cyc;
      if (exp_rd[ch] == exp_wr[ch])
        check(0, "R8 unexpected word", int'(out_data), 0);
      else begin
        check(out_data == exp_mem[ch][exp_rd[ch] % 32],
              "R3 R5 R6 R7 R8 word", int'(out_data), int'(exp_mem[ch][exp_rd[ch] % 32]));
        exp_rd[ch]++;
      end
    end
    begin
      int c;
      bit tk;
      c = cyc % NCH;
      tk = (c % 2 == 0) ? 1'b1 : vcnt[c][0];
      vcnt[c]++;
      if (tk && !busy[c] && req_wr[c] != req_rd[c]) begin
        frame[c] = req_frame[c]; nb[c] = req_nb[c]; tpb[c] = req_tpb[c];
        busy[c] = 1; bitpos[c] = 0; tkc[c] = 0; req_rd[c]++;
        tx_start[c] = cyc;
      end
      rx_ch    = 4'(c);
      rx_tick  = tk;
      rx_level = busy[c] ? frame[c][bitpos[c]] : 1'b1;
      if (tk && busy[c]) begin
        tkc[c]++;
        if (tkc[c] == tpb[c]) begin
          tkc[c] = 0; bitpos[c]++;
          if (bitpos[c] == nb[c]) busy[c] = 0;
        end
      end
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic post_raw(input int c, input logic [15:0] f, input int n, input int t);
    while (req_wr[c] != req_rd[c]) wait_clks(1);
    req_frame[c] = f; req_nb[c] = n; req_tpb[c] = t;
    req_wr[c]++;
  endtask

  task automatic send(input int c, input logic [7:0] d, input bit s1, input bit s2, input bit two);
    logic [15:0] f;
    int n;
    f = '1;
    f[0] = 1'b0; f[8:1] = d; f[9] = s1;
    n = 10;
    if (two) begin f[10] = s2; n = 11; end
    if (!s1 || (two && !s2)) n++;
    exp_mem[c][exp_wr[c] % 32] = exp_word(c, d, s1);
    exp_wr[c]++;
    post_raw(c, f, n, OVS);
  endtask

  task automatic wait_idle();
    int guard = 0;
    bit idle = 0;
    while (!idle && guard < 20000) begin
      wait_clks(1);
      guard++;
      idle = !out_valid;
      for (int c = 0; c < NCH; c++)
        if (busy[c] || req_wr[c] != req_rd[c]) idle = 0;
    end
    wait_clks(4 * BITCLK);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchecks++; nerrs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

  initial begin : main
    int p0, elapsed;
    logic [15:0] held;
    void'($urandom(32'h1234abcd));
    wait_clks(5);
    // R11 reset state
    check(out_valid == 0, "R11 out_valid after reset", out_valid, 0);
    check(overflow == 0, "R11 overflow after reset", overflow, 0);
    rst_n = 1; out_ready = 1;
    wait_clks(4 * BITCLK);
    check(out_valid == 0, "R11 R1 idle lines give no word", out_valid, 0);

    // R2 glitch shorter than half bit is rejected
    p0 = pop_total;
    post_raw(6, 16'h0000, 1, 2);
    wait_clks(4 * BITCLK);
    check(pop_total == p0, "R2 glitch produces no word", pop_total - p0, 0);

    // R1 R4 one stop latency
    send(4, 8'hA5, 1, 1, 0);
    wait_idle();
    elapsed = last_pop[4] - tx_start[4];
    check(elapsed >= 9 * BITCLK && elapsed < 10 * BITCLK, "R1 R4 one-stop completion time", elapsed, 9 * BITCLK + BITCLK / 2);

    // R5 framing, R6 break
    send(2, 8'h3C, 0, 1, 0);
    send(8, 8'h00, 0, 1, 0);
    send(10, 8'h00, 1, 1, 0);
    wait_idle();

    // R4 two stop bits: later completion, second stop level ignored
    two_stop = 1;
    wait_clks(2);
    send(4, 8'h5A, 1, 0, 1);
    wait_idle();
    elapsed = last_pop[4] - tx_start[4];
    check(elapsed >= 10 * BITCLK && elapsed < 11 * BITCLK, "R4 two-stop completion time", elapsed, 10 * BITCLK + BITCLK / 2);
    send(12, 8'h81, 1, 1, 1);
    send(3, 8'h7E, 0, 1, 1);
    wait_idle();
    two_stop = 0;
    wait_clks(2);

    // R8 random overlapping traffic on all channels
    for (int r = 0; r < 20; r++)
      for (int c = 0; c < NCH; c++)
        send(c, 8'($urandom), ($urandom % 8) != 0, 1, 0);
    wait_idle();
    begin
      int left = 0;
      for (int c = 0; c < NCH; c++) left += exp_wr[c] - exp_rd[c];
      check(left == 0, "R8 all expected words delivered", left, 0);
    end
    check(overflow == 0, "R10 no overflow with ready high", overflow, 0);

    // R9 R10 overflow with consumer stalled
    out_ready = 0;
    for (int c = 0; c < 8; c++) send(c, 8'(8'h10 + c), 1, 1, 0);
    wait_clks(14 * BITCLK * 2);
    check(overflow == 1, "R10 overflow set when full", overflow, 1);
    check(out_valid == 1, "R9 valid while holding words", out_valid, 1);
    held = out_data;
    wait_clks(7);
    check(out_data == held, "R9 head stable while not ready", int'(out_data), int'(held));
    p0 = pop_total;
    out_ready = 1;
    wait_clks(30);
    check(pop_total - p0 == DEPTH, "R10 words kept equal depth", pop_total - p0, DEPTH);
    check(overflow == 1, "R10 overflow sticky", overflow, 1);
    flush_req++;
    wait_clks(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

endmodule